// File: doc/BRIEF.md
# Multi-Level Priority Interrupt Controller

This block gathers a vector of interrupt request lines into a pending register. Each line has a fixed type that sets how its pending bit clears. A level-type bit follows its input: it drops when the input goes low. An edge-type bit stays set after its input falls, and only software clears it. Software can also set and clear pending bits through write-one ports, and it loads an enable register that gates which pending bits may raise a request.

The AND of the pending and enable registers forms the effective set. Each priority level has a configurable mask that names the lines belonging to it. The controller scans the levels from the highest down and considers only levels strictly above the level the core is currently running at. The first level whose mask intersects the effective set becomes the reported level, and the request output is raised. When no level qualifies, the reported level is zero and the request is low. Lines whose index is at or above the configured active-line count never latch.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While input line i (below the active count) is high at a clock edge, pending bit i is 1 after that edge.
- R2: A level-type line (`line_kind` bit = 1) that is low, with no software set in the same cycle, has its pending bit cleared at that edge.
- R3: An edge-type line (`line_kind` bit = 0) keeps its pending bit set after the input falls, until a software clear arrives.
- R4: A 1 on `sw_set[i]` sets pending bit i. A 1 on `sw_clr[i]` clears it. If a set source is active in the same cycle (the input is high or `sw_set[i]` is 1), the set wins and the bit stays 1.
- R5: When `en_wr` is 1, the enable register takes `en_data` at that edge; otherwise it holds its value. Only bits set in both the pending and enable registers can cause a request.
- R6: Level k (1..N_LEVELS) owns the lines in `level_mask[(k-1)*N_LINES +: N_LINES]`. The reported level is the highest k greater than `core_level` whose mask intersects pending AND enable, and `irq_req` is 1 in that case.
- R7: When no level qualifies, `irq_level` is 0 and `irq_req` is 0.
- R8: Lines with index at or above ACTIVE_LINES are ignored: their pending and enable bits stay 0 whatever the input, software set or enable write.
- R9: `irq_req` and `irq_level` are registered. After the clock edge that updates pending and enable, they reflect the new pending and enable values and the `core_level` sampled at that edge.
- R10: While `rst_n` is low, pending, enable, `irq_req` and `irq_level` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | N_LINES | Interrupt request lines |
| line_kind | input | N_LINES | Per-line type: 1 level, 0 edge/software |
| sw_set | input | N_LINES | Write-one-to-set pending |
| sw_clr | input | N_LINES | Write-one-to-clear pending |
| en_wr | input | 1 | Enable register write strobe |
| en_data | input | N_LINES | Enable register write data |
| core_level | input | LVL_W | Current interrupt level of the core |
| level_mask | input | N_LEVELS*N_LINES | Per-level line membership masks |
| pend_q | output | N_LINES | Pending register |
| en_q | output | N_LINES | Enable register |
| irq_req | output | 1 | Interrupt request to the core |
| irq_level | output | LVL_W | Level being requested, 0 when none |

## Verification
Every result is due one clock edge after its stimulus. The pending bits, the enable bits, the request and the level all update on the same edge that samples the inputs and `core_level`. The bench drives inputs on the falling edge. On each rising edge it advances a behavioural model using the values then stable. On the next falling edge it compares all four outputs with the model. This puts every comparison exactly one edge after the stimulus it judges.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  typedef enum logic {
    LINE_EDGE  = 1'b0,
    LINE_LEVEL = 1'b1
  } line_kind_e;
endpackage

// File: rtl/irq_pend_latch.sv
module irq_pend_latch
  import irq_prio_pkg::*;
#(
  parameter int N_LINES      = 32,
  parameter int ACTIVE_LINES = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_in,
  input  logic [N_LINES-1:0] line_kind,
  input  logic [N_LINES-1:0] sw_set,
  input  logic [N_LINES-1:0] sw_clr,
  input  logic               en_wr,
  input  logic [N_LINES-1:0] en_data,
  output logic [N_LINES-1:0] pend_d,
  output logic [N_LINES-1:0] en_d,
  output logic [N_LINES-1:0] pend_q,
  output logic [N_LINES-1:0] en_q
);
  // named per-line events, visible to assertions
  logic [N_LINES-1:0] set_ev;
  logic [N_LINES-1:0] clr_ev;

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    if (i < ACTIVE_LINES) begin : g_on
      assign set_ev[i] = irq_in[i] | sw_set[i];
      assign clr_ev[i] = sw_clr[i] | ((line_kind[i] == LINE_LEVEL) & ~irq_in[i]);
      assign pend_d[i] = set_ev[i] | (pend_q[i] & ~clr_ev[i]);
      assign en_d[i]   = en_wr ? en_data[i] : en_q[i];

      assert_line_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
        irq_in[i] |=> pend_q[i]);
      assert_level_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (line_kind[i] && !irq_in[i] && !sw_set[i]) |=> !pend_q[i]);
      assert_edge_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_kind[i] && pend_q[i] && !sw_clr[i]) |=> pend_q[i]);
      assert_sw_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_clr[i] && !sw_set[i] && !irq_in[i]) |=> !pend_q[i]);
      assert_enable_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr |=> (en_q[i] == $past(en_data[i])));
    end else begin : g_off
      assign set_ev[i] = 1'b0;
      assign clr_ev[i] = 1'b0;
      assign pend_d[i] = 1'b0;
      assign en_d[i]   = 1'b0;

      assert_unused_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_q[i] && !en_q[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      pend_q <= pend_d;
      en_q   <= en_d;
    end
  end
endmodule

// File: rtl/irq_level_scan.sv
module irq_level_scan #(
  parameter int N_LINES  = 32,
  parameter int N_LEVELS = 7,
  parameter int LVL_W    = $clog2(N_LEVELS + 1)
) (
  input  logic [N_LINES-1:0]          eff,
  input  logic [N_LEVELS*N_LINES-1:0] level_mask,
  input  logic [LVL_W-1:0]            core_level,
  output logic [N_LEVELS-1:0]         level_hit,
  output logic [LVL_W-1:0]            top_level
);
  // highest set hit bit, reported as its level number (index + 1)
  function automatic logic [LVL_W-1:0] highest_hit(input logic [N_LEVELS-1:0] h);
    logic [LVL_W-1:0] r;
    r = '0;
    for (int k = 0; k < N_LEVELS; k++) begin
      if (h[k]) r = LVL_W'(k + 1);
    end
    return r;
  endfunction

  for (genvar k = 1; k <= N_LEVELS; k++) begin : g_lvl
    assign level_hit[k-1] = (LVL_W'(k) > core_level) &&
                            (|(level_mask[(k-1)*N_LINES +: N_LINES] & eff));
  end

  assign top_level = highest_hit(level_hit);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int N_LINES      = 32,
  parameter int N_LEVELS     = 7,
  parameter int ACTIVE_LINES = 32,
  localparam int LVL_W       = $clog2(N_LEVELS + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_LINES-1:0]          irq_in,
  input  logic [N_LINES-1:0]          line_kind,
  input  logic [N_LINES-1:0]          sw_set,
  input  logic [N_LINES-1:0]          sw_clr,
  input  logic                        en_wr,
  input  logic [N_LINES-1:0]          en_data,
  input  logic [LVL_W-1:0]            core_level,
  input  logic [N_LEVELS*N_LINES-1:0] level_mask,
  output logic [N_LINES-1:0]          pend_q,
  output logic [N_LINES-1:0]          en_q,
  output logic                        irq_req,
  output logic [LVL_W-1:0]            irq_level
);
  logic [N_LINES-1:0]  pend_d;
  logic [N_LINES-1:0]  en_d;
  logic [N_LINES-1:0]  eff_next;
  logic [N_LEVELS-1:0] level_hit;
  logic [LVL_W-1:0]    scan_level;

  irq_pend_latch #(
    .N_LINES(N_LINES),
    .ACTIVE_LINES(ACTIVE_LINES)
  ) u_latch (
    .clk(clk), .rst_n(rst_n),
    .irq_in(irq_in), .line_kind(line_kind),
    .sw_set(sw_set), .sw_clr(sw_clr),
    .en_wr(en_wr), .en_data(en_data),
    .pend_d(pend_d), .en_d(en_d),
    .pend_q(pend_q), .en_q(en_q)
  );

  // scan the next-state registers so the outputs line up with pend_q/en_q
  assign eff_next = pend_d & en_d;

  irq_level_scan #(
    .N_LINES(N_LINES),
    .N_LEVELS(N_LEVELS),
    .LVL_W(LVL_W)
  ) u_scan (
    .eff(eff_next),
    .level_mask(level_mask),
    .core_level(core_level),
    .level_hit(level_hit),
    .top_level(scan_level)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_req   <= 1'b0;
      irq_level <= '0;
    end else begin
      irq_req   <= (scan_level != '0);
      irq_level <= scan_level;
    end
  end

  assert_above_core_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_level > $past(core_level)));
  assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> (irq_level == '0));
  assert_req_has_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (|(pend_q & en_q)));
  assert_no_hit_no_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (level_hit == '0) |=> !irq_req);
endmodule

// File: tb/sim_irq_prio_ctrl.sv
module sim_irq_prio_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 32;
  localparam int NLV = 7;
  localparam int ACT = 24;
  localparam int LW  = $clog2(NLV + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] irq_in = '0, line_kind = '0, sw_set = '0, sw_clr = '0, en_data = '0;
  logic en_wr = 1'b0;
  logic [LW-1:0] core_level = '0;
  logic [NLV*N-1:0] level_mask = '0;
  logic [N-1:0] pend_q, en_q;
  logic irq_req;
  logic [LW-1:0] irq_level;

  irq_prio_ctrl #(.N_LINES(N), .N_LEVELS(NLV), .ACTIVE_LINES(ACT)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .line_kind(line_kind),
    .sw_set(sw_set), .sw_clr(sw_clr), .en_wr(en_wr), .en_data(en_data),
    .core_level(core_level), .level_mask(level_mask),
    .pend_q(pend_q), .en_q(en_q), .irq_req(irq_req), .irq_level(irq_level));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_req = "R10";

  // behavioural reference state
  bit m_pend[N];
  bit m_en[N];
  int m_level = 0;

  task automatic chk(string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  function automatic logic [N-1:0] pack(input bit v[N]);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = v[i];
    return r;
  endfunction

  task automatic model_edge();
    for (int i = 0; i < ACT; i++) begin
      if (irq_in[i] || sw_set[i]) m_pend[i] = 1;
      else if (sw_clr[i]) m_pend[i] = 0;
      else if (line_kind[i] && !irq_in[i]) m_pend[i] = 0;
      if (en_wr) m_en[i] = en_data[i];
    end
    m_level = 0;
    for (int k = NLV; k >= 1; k--) begin
      if (m_level == 0 && k > int'(core_level)) begin
        for (int i = 0; i < N; i++)
          if (level_mask[(k-1)*N + i] && m_pend[i] && m_en[i]) m_level = k;
      end
    end
  endtask

  task automatic step();
    @(posedge clk);
    if (rst_n) model_edge();
    @(negedge clk);
    chk("pend", pend_q, pack(m_pend));
    chk("enable", en_q, pack(m_en));
    chk("req", irq_req, (m_level != 0));
    chk("level", irq_level, m_level);
    sw_set = '0; sw_clr = '0; en_wr = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf = 32'h1ace_b00c;
    for (int i = 0; i < N; i++) begin m_pend[i] = 0; m_en[i] = 0; end
    line_kind = 32'h0000_00ff;           // lines 0..7 level, rest edge
    for (int k = 1; k <= 6; k++)
      for (int i = 0; i < 4; i++) level_mask[(k-1)*N + (k-1)*4 + i] = 1'b1;
    level_mask[6*N + 0] = 1'b1;          // level 7 holds line 0
    for (int i = 28; i < 32; i++) level_mask[6*N + i] = 1'b1;  // and inactive lines
    irq_in = 32'hffff_ffff; sw_set = '1; en_wr = 1; en_data = '1;
    // R10 reset state
    cur_req = "R10";
    repeat (2) step();
    irq_in = '0;
    rst_n = 1;
    // R1 edge line 10 asserts
    cur_req = "R1"; irq_in[10] = 1; step();
    // R3 edge line 10 falls, stays
    cur_req = "R3"; irq_in[10] = 0; step(); step();
    // R2 level line 2
    cur_req = "R2"; irq_in[2] = 1; step(); irq_in[2] = 0; step();
    // R4 sw set/clear and set-wins
    cur_req = "R4"; sw_set[15] = 1; step();
    sw_clr[10] = 1; step();
    irq_in[5] = 1; sw_clr[5] = 1; step();
    irq_in[12] = 1; sw_clr[12] = 1; step();
    irq_in[12] = 0; step();
    sw_set[20] = 1; sw_clr[20] = 1; step();
    // R5 enable writes, nothing enabled yet so no request
    cur_req = "R5"; step();
    en_wr = 1; en_data = 32'h0000_8000; step();
    step();
    // R6 enable all, sweep core level
    cur_req = "R6"; en_wr = 1; en_data = '1; step();
    for (int c = 0; c <= NLV; c++) begin core_level = LW'(c); step(); end
    // R7 nothing qualifies
    cur_req = "R7"; core_level = LW'(NLV); step();
    core_level = 0; sw_clr = '1; irq_in = '0; step(); step();
    // R8 inactive lines
    cur_req = "R8"; irq_in[30:24] = '1; sw_set[31:28] = '1; en_wr = 1; en_data = '1; step();
    irq_in = '0; step();
    // R9 mixed traffic, every cycle compared one edge after stimulus
    cur_req = "R9";
    for (int t = 0; t < 400; t++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      irq_in = lf & 32'h0421_0843;
      sw_set = (t % 7 == 0) ? (lf >> 3) & 32'h0101_1010 : '0;
      sw_clr = (t % 5 == 0) ? ~lf : '0;
      en_wr = (t % 11 == 0); en_data = lf ^ 32'h5a5a_a5a5;
      core_level = LW'(lf[6:4]);
      step();
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule